// File: doc/BRIEF.md
# Flash Page Staging Buffer

This block holds one flash page worth of 16-bit words while software assembles it, ahead of an erase, write or erase-and-write of a page. Each load request carries a byte address and a data word. The word lands in the slot picked by the low word-address bits. Bit 0 of the address is discarded because the array is word-addressed. Address bits above the slot field are discarded as well. A per-slot marker records which slots hold loaded data, and an active-loading flag shows that filling has begun.

Each slot accepts one word per fill cycle. A second load to a slot that is already filled is dropped, and a sticky overwrite-error bit is raised. A flush request, or the flash controller's report that a page write has finished, empties the buffer. Emptying returns every slot to the erased value 0xFFFF. The page image is always presented whole: slots that were never loaded show 0xFFFF, so a commit always covers the entire page.

Top module: `fpb_page_buffer`

## Requirements
- R1: After reset every slot reads 0xFFFF, no slot is marked loaded, and both the loading flag and the overwrite error are 0.
- R2: A load writes load_data into slot number load_addr[SLOT_W:1], with SLOT_W = log2(PAGE_WORDS). Bit 0 and all bits above SLOT_W are ignored. Slot k occupies page_image[16k+15:16k] and loaded_mask[k], and the new value appears the cycle after the load.
- R3: loading_flag rises the cycle after the first accepted load following reset or an emptying.
- R4: While no flush and no write completion occurs, the loaded words, the markers and the flag hold their values.
- R5: A load to a slot whose marker is already set leaves that slot's data unchanged.
- R6: Such a rejected load sets ovr_err the following cycle. ovr_err then stays 1 until reset, including through flushes and write completions.
- R7: A flush_en pulse returns every slot to 0xFFFF, clears all markers and clears loading_flag on the next cycle.
- R8: A write_done pulse empties the buffer with the same effect as a flush.
- R9: When a flush or write completion coincides with a load, the emptying wins. The load is discarded and does not set ovr_err.
- R10: Slots that were not loaded since the last emptying read 0xFFFF in page_image.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Load request for one word |
| load_addr | input | ADDR_W | Byte address of the word |
| load_data | input | 16 | Word to store |
| flush_en | input | 1 | Empty the buffer |
| write_done | input | 1 | A page write finished; empty the buffer |
| page_image | output | 16*PAGE_WORDS | Whole page, slot k at bits 16k+15:16k |
| loaded_mask | output | PAGE_WORDS | Per-slot loaded markers |
| loading_flag | output | 1 | Active-loading status |
| ovr_err | output | 1 | Sticky error for a repeated slot load |

## Verification
Several properties are checked on every cycle:
- the flag agrees with the marker set;
- the slot decode never selects more than one slot;
- a rejected load leaves its slot's word untouched;
- an emptying leaves no marker and no flag behind;
- the error bit never falls.

Only the directed scenarios can show where a given address lands, that the ignored address bits really have no effect, and that a clear wins over a simultaneous load. The same holds for unloaded slots reading as erased and for the error surviving a flush.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  typedef logic [15:0] word_t;
  localparam word_t ERASED_WORD = 16'hFFFF;
endpackage

// File: rtl/fpb_slot_decode.sv
module fpb_slot_decode #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_WORDS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [ADDR_W-1:0]     addr,
  output logic [PAGE_WORDS-1:0] hit
);
  localparam int SLOT_W = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;

  // Word slot from a byte address: drop bit 0, keep SLOT_W bits above it.
  function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[SLOT_W:1];
  endfunction

  logic [SLOT_W-1:0] slot_sel;
  assign slot_sel = slot_of(addr);

  for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_hit
    assign hit[i] = en && (slot_sel == SLOT_W'(i));
  end

  // R2
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
endmodule

// File: rtl/fpb_slot.sv
module fpb_slot
  import fpb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  hit,
  input  word_t din,
  output word_t word,
  output logic  loaded,
  output logic  accept,
  output logic  reject
);
  assign accept = hit && !loaded && !clr;
  assign reject = hit &&  loaded && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word   <= ERASED_WORD;
      loaded <= 1'b0;
    end else if (clr) begin
      word   <= ERASED_WORD;
      loaded <= 1'b0;
    end else if (accept) begin
      word   <= din;
      loaded <= 1'b1;
    end
  end

  // R5
  reject_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> $stable(word));
  // R10
  unloaded_erased_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> (word == ERASED_WORD));
endmodule

// File: rtl/fpb_page_buffer.sv
module fpb_page_buffer
  import fpb_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic [ADDR_W-1:0]        load_addr,
  input  logic [15:0]              load_data,
  input  logic                     flush_en,
  input  logic                     write_done,
  output logic [16*PAGE_WORDS-1:0] page_image,
  output logic [PAGE_WORDS-1:0]    loaded_mask,
  output logic                     loading_flag,
  output logic                     ovr_err
);
  logic                  clr_evt;
  logic [PAGE_WORDS-1:0] slot_hit;
  logic [PAGE_WORDS-1:0] slot_accept;
  logic [PAGE_WORDS-1:0] slot_reject;
  logic                  any_accept;
  logic                  any_reject;

  assign clr_evt = flush_en || write_done;

  fpb_slot_decode #(.ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(load_en), .addr(load_addr), .hit(slot_hit)
  );

  for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_slot
    fpb_slot u_slot (
      .clk(clk), .rst_n(rst_n), .clr(clr_evt), .hit(slot_hit[i]), .din(load_data),
      .word(page_image[16*i +: 16]), .loaded(loaded_mask[i]),
      .accept(slot_accept[i]), .reject(slot_reject[i])
    );
  end

  assign any_accept = |slot_accept;
  assign any_reject = |slot_reject;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          loading_flag <= 1'b0;
    else if (clr_evt)    loading_flag <= 1'b0;
    else if (any_accept) loading_flag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovr_err <= 1'b0;
    else if (any_reject) ovr_err <= 1'b1;
  end

  // R3
  flag_matches_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loading_flag == (loaded_mask != '0));
  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (loaded_mask == '0) && !loading_flag);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |=> ovr_err);
  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && !load_en) |=> $stable(loaded_mask));
endmodule

// File: tb/sim_fpb_page_buffer.sv
module sim_fpb_page_buffer;
  localparam int AW = 12;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [15:0] load_data = '0;
  logic flush_en = 1'b0;
  logic write_done = 1'b0;
  logic [16*PW-1:0] page_image;
  logic [PW-1:0] loaded_mask;
  logic loading_flag;
  logic ovr_err;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_word [PW];
  logic [PW-1:0] exp_mask;
  logic exp_flag, exp_err;

  always #10 clk = ~clk;

  fpb_page_buffer #(.ADDR_W(AW), .PAGE_WORDS(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .flush_en(flush_en), .write_done(write_done),
    .page_image(page_image), .loaded_mask(loaded_mask),
    .loading_flag(loading_flag), .ovr_err(ovr_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < PW; k++) chk(req, $sformatf("slot%0d", k), 32'(page_image[16*k +: 16]), 32'(exp_word[k]));
    chk(req, "mask", 32'(loaded_mask), 32'(exp_mask));
    chk(req, "flag", 32'(loading_flag), 32'(exp_flag));
    chk(req, "err", 32'(ovr_err), 32'(exp_err));
  endtask

  task automatic model_empty();
    for (int k = 0; k < PW; k++) exp_word[k] = 16'hFFFF;
    exp_mask = '0;
    exp_flag = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [15:0] d);
    int s;
    @(negedge clk);
    load_en = 1'b1; load_addr = a; load_data = d;
    @(negedge clk);
    load_en = 1'b0;
    s = (a >> 1) % PW;
    if (exp_mask[s]) exp_err = 1'b1;
    else begin exp_word[s] = d; exp_mask[s] = 1'b1; exp_flag = 1'b1; end
  endtask

  task automatic do_clear(input bit use_write);
    @(negedge clk);
    if (use_write) write_done = 1'b1; else flush_en = 1'b1;
    @(negedge clk);
    write_done = 1'b0; flush_en = 1'b0;
    model_empty();
  endtask

  task automatic t_reset();
    model_empty(); exp_err = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
  endtask

  task automatic t_basic();
    do_load(12'h006, 16'hA5A5);
    check_all("R2");
    chk("R3", "flag after first load", 32'(loading_flag), 32'd1);
    check_all("R10");
  endtask

  task automatic t_addr_bits();
    do_load(12'hF0B, 16'h1357);
    chk("R2", "slot5 from upper/lsb address", 32'(page_image[16*5 +: 16]), 32'h1357);
    check_all("R2");
  endtask

  task automatic t_double();
    do_load(12'h806, 16'h1234);
    chk("R5", "slot3 unchanged", 32'(page_image[16*3 +: 16]), 32'hA5A5);
    chk("R6", "error set", 32'(ovr_err), 32'd1);
    check_all("R5");
  endtask

  task automatic t_flush();
    do_clear(1'b0);
    check_all("R7");
    chk("R6", "error survives flush", 32'(ovr_err), 32'd1);
  endtask

  task automatic t_write();
    do_load(12'h000, 16'h0F0F);
    do_load(12'h00E, 16'hF0F0);
    check_all("R2");
    do_clear(1'b1);
    check_all("R8");
  endtask

  task automatic t_priority();
    @(negedge clk);
    flush_en = 1'b1; load_en = 1'b1; load_addr = 12'h004; load_data = 16'hBEEF;
    @(negedge clk);
    flush_en = 1'b0; load_en = 1'b0;
    model_empty();
    check_all("R9");
    @(negedge clk);
    write_done = 1'b1; load_en = 1'b1; load_addr = 12'h002; load_data = 16'hCAFE;
    @(negedge clk);
    write_done = 1'b0; load_en = 1'b0;
    check_all("R9");
  endtask

  task automatic t_fill();
    t_reset();
    for (int k = 0; k < PW; k++) do_load(AW'(2*k), 16'h4000 + 16'(k * 3));
    check_all("R2");
    repeat (5) @(negedge clk);
    check_all("R4");
    do_load(12'h00A, 16'h0000);
    check_all("R6");
    do_clear(1'b1);
    check_all("R8");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_addr_bits();
    t_double();
    t_flush();
    t_write();
    t_priority();
    t_fill();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule